// File: doc/BRIEF.md
# Instruction line aligner

This block sits between instruction fetch and dispatch. Fetch delivers 128-bit lines of four 32-bit words. An execution line is one to four consecutive words, and its last word carries an end flag in bit 31. Code is packed without alignment, so an execution line can begin in one fetched line and finish in the next.

The block stores the accepted words in a ring that holds five fetched lines. Each cycle it looks at the oldest four stored words. It presents the complete execution line at their head to dispatch as a four-slot vector with a slot mask. When fetch lands on a branch target in the middle of a line, it gives a count of leading words to discard. A flush from a redirect empties the ring in one cycle.

Top module: `insn_line_aligner`

## Requirements
- R1: After reset `out_valid` is 0, `out_err` is 0, `out_mask` is 0 and `fetch_ready` is 1.
- R2: `fetch_ready` is 1 exactly when at least four word slots are free, meaning at most 16 of the 20 are occupied. A line is accepted when `fetch_valid` and `fetch_ready` are both high in a cycle without `flush`.
- R3: An emitted execution line runs from the oldest stored word up to and including the first word with bit 31 set, giving n words (1 to 4). The oldest word goes in slot 0, at bits [31:0]. `out_mask` has its low n bits set, and the unused slots read as zero.
- R4: An execution line whose words come from two fetched lines is emitted once its last word has been accepted, with the words in program order.
- R5: While fewer than four words are stored and none of them has its end flag set, `out_valid` and `out_err` both stay 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, the line and mask stay unchanged in the next cycle. The line is removed only in a cycle with `out_ready` high.
- R7: `flush` discards every stored word in one cycle, and a line offered by fetch in that same cycle is dropped. In the next cycle `out_valid` is 0 and `fetch_ready` is 1.
- R8: If the four oldest words carry no end flag, `out_err` is 1 and `out_valid` is 0 for that cycle. Those four words are then dropped whatever the value of `out_ready`.
- R9: `fetch_skip` = s (0 to 3) discards the s lowest words of the accepted line, and only words s to 3 are stored.
- R10: The ring never holds more than 20 words. With dispatch stalled, exactly 5 full lines are accepted, or 17 lines when `fetch_skip` is 3.
- R11: The order of words is kept across lines: every word is emitted exactly once, in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all buffered words |
| fetch_valid | input | 1 | A fetched line is offered |
| fetch_ready | output | 1 | Room for one more fetched line |
| fetch_line | input | 128 | Four words; word 0 (earliest) at bits [31:0] |
| fetch_skip | input | 2 | Leading words of the line to discard |
| out_valid | output | 1 | A complete execution line is presented |
| out_ready | input | 1 | Dispatch takes the presented line |
| out_line | output | 128 | Execution line, slot 0 at bits [31:0] |
| out_mask | output | 4 | Occupied slots |
| out_err | output | 1 | Four words with no end flag |

## Verification
A long stream of execution lines, with lengths varying over every value from 1 to 4, is packed densely into fetched lines. Fetch and dispatch stall in patterns that do not line up, so lines split across fetched-line boundaries at every offset. A design that computed the split wrongly would emit reordered, merged or missing words. Targeted cases cover these:
- A partial line with no end flag, where an early emitter would send truncated lines.
- An unmarked four-word run, where a missing error path would hang.
- The fill limits with and without skipping, where an off-by-one in the room test would overflow or starve.
- A flush that coincides with a fetch, where leaking that line would emit stale code.

// File: rtl/insn_line_aligner.sv
module insn_line_aligner #(
  parameter int WORD_W      = 32,
  parameter int SLOTS       = 4,
  parameter int DEPTH_LINES = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fetch_valid,
  output logic                      fetch_ready,
  input  logic [WORD_W*SLOTS-1:0]   fetch_line,
  input  logic [$clog2(SLOTS)-1:0]  fetch_skip,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W*SLOTS-1:0]   out_line,
  output logic [SLOTS-1:0]          out_mask,
  output logic                      out_err
);
  localparam int DEPTH = DEPTH_LINES * SLOTS;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LW    = $clog2(SLOTS) + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [PW-1:0] wrap(input int unsigned p);
    return PW'(p >= DEPTH ? p - DEPTH : p);
  endfunction

  logic [WORD_W-1:0] head [SLOTS];
  logic [SLOTS-1:0]  mark;
  logic              found;
  logic [LW-1:0]     len;
  logic [LW-1:0]     pop_n, push_n;
  logic              push_en;

  for (genvar i = 0; i < SLOTS; i++) begin : g_head
    assign head[i] = mem[wrap(int'(rd_q) + i)];
    assign mark[i] = (int'(cnt_q) > i) && head[i][WORD_W-1];
    assign out_mask[i] = found && (i < int'(len));
    assign out_line[i*WORD_W +: WORD_W] = out_mask[i] ? head[i] : '0;
  end

  always_comb begin
    found = 1'b0;
    len   = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (mark[i]) begin
        found = 1'b1;
        len   = LW'(i + 1);
      end
  end

  assign out_valid   = found;
  assign out_err     = !found && (int'(cnt_q) >= SLOTS);
  assign fetch_ready = int'(cnt_q) <= DEPTH - SLOTS;
  assign push_en     = fetch_valid && fetch_ready && !flush;
  assign push_n      = push_en ? LW'(SLOTS - int'(fetch_skip)) : '0;
  assign pop_n       = (out_valid && out_ready) ? len : out_err ? LW'(SLOTS) : '0;

  always_ff @(posedge clk)
    for (int i = 0; i < SLOTS; i++)
      if (push_en && i >= int'(fetch_skip))
        mem[wrap(int'(wr_q) + i - int'(fetch_skip))] <= fetch_line[i*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= wrap(int'(rd_q) + int'(pop_n));
      wr_q  <= wrap(int'(wr_q) + int'(push_n));
      cnt_q <= CW'(int'(cnt_q) + int'(push_n) - int'(pop_n));
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  p_err_not_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  p_mask_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask == 4'b0001 || out_mask == 4'b0011 ||
                   out_mask == 4'b0111 || out_mask == 4'b1111));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_line) && $stable(out_mask)));
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !out_err && fetch_ready));
endmodule

// File: tb/insn_line_aligner_bench.sv
`timescale 1ns/1ps
module insn_line_aligner_bench;
  logic clk = 0, rst_n = 0, flush = 0, fetch_valid = 0, out_ready = 0;
  logic [127:0] fetch_line = '0;
  logic [1:0] fetch_skip = '0;
  logic fetch_ready, out_valid, out_err;
  logic [127:0] out_line;
  logic [3:0] out_mask;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  insn_line_aligner u_insn_line_aligner (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_line(fetch_line), .fetch_skip(fetch_skip),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_mask(out_mask), .out_err(out_err));

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit e, input int v);
    return {e, 31'(v)};
  endfunction

  task automatic do_flush();
    @(negedge clk); flush = 1; fetch_valid = 0;
    @(negedge clk); flush = 0;
  endtask

  logic [31:0] wv [0:1023];
  int lstart [0:511];
  int llen [0:511];

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nl, nw, fi, li, acc;
    logic [127:0] e;
    logic [3:0] em;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!out_valid && !out_err && out_mask == 0 && fetch_ready, "R1 reset state",
          {out_valid, out_err, out_mask, fetch_ready}, 7'b0000001);

    // R3 R4 R11: dense stream with all lengths, stalls on both sides
    nl = 0; nw = 0;
    for (int k = 0; k < 150; k++) begin
      llen[nl] = ((k * 5 + k / 3) % 4) + 1;
      lstart[nl] = nw;
      for (int j = 0; j < llen[nl]; j++) begin
        wv[nw] = mk(j == llen[nl] - 1, 1000 + nw);
        nw++;
      end
      nl++;
    end
    while (nw % 4 != 0) begin
      llen[nl] = 1; lstart[nl] = nw; wv[nw] = mk(1, 1000 + nw); nw++; nl++;
    end
    fi = 0; li = 0;
    for (int c = 0; c < 6000 && li < nl; c++) begin
      @(negedge clk);
      fetch_valid = (fi < nw) && (c % 5 != 3);
      fetch_skip = 0;
      if (fi < nw) fetch_line = {wv[fi+3], wv[fi+2], wv[fi+1], wv[fi]};
      out_ready = (c % 3 != 1);
      #1;
      if (out_err) check(0, "R8 no error on well-formed stream", 1, 0);
      if (out_valid && out_ready) begin
        e = '0; em = '0;
        for (int j = 0; j < llen[li]; j++) begin
          e[j*32 +: 32] = wv[lstart[li] + j];
          em[j] = 1'b1;
        end
        check(out_line == e && out_mask == em, "R3 R4 R11 stream line", out_line, e);
        li++;
      end
      if (fetch_valid && fetch_ready) fi += 4;
    end
    check(li == nl, "R11 all lines emitted", 128'(li), 128'(nl));
    @(negedge clk); fetch_valid = 0; out_ready = 0;

    // R5 R4: partial line waits, then completes across boundary
    do_flush();
    @(negedge clk);
    fetch_valid = 1; fetch_skip = 2;
    fetch_line = {mk(0, 11), mk(0, 10), mk(1, 9), mk(1, 8)};
    @(negedge clk); fetch_valid = 0; fetch_skip = 0; #1;
    check(!out_valid && !out_err, "R5 R9 no emission without end flag", {out_valid, out_err}, 0);
    fetch_valid = 1;
    fetch_line = {mk(1, 15), mk(0, 14), mk(1, 13), mk(1, 12)};
    @(negedge clk); fetch_valid = 0; out_ready = 1; #1;
    check(out_valid && out_mask == 4'b0111 && out_line == {32'h0, mk(1, 12), mk(0, 11), mk(0, 10)},
          "R4 R9 straddling line", out_line, {32'h0, mk(1, 12), mk(0, 11), mk(0, 10)});
    @(negedge clk); #1;
    check(out_valid && out_mask == 4'b0001 && out_line == {96'h0, mk(1, 13)},
          "R3 single-word line", out_line, {96'h0, mk(1, 13)});
    @(negedge clk); #1;
    check(out_valid && out_mask == 4'b0011 && out_line == {64'h0, mk(1, 15), mk(0, 14)},
          "R3 two-word line", out_line, {64'h0, mk(1, 15), mk(0, 14)});
    @(negedge clk); out_ready = 0; #1;
    check(!out_valid, "R11 drained", out_valid, 0);

    // R9: skip one word
    @(negedge clk);
    fetch_valid = 1; fetch_skip = 1;
    fetch_line = {mk(1, 23), mk(1, 22), mk(0, 21), mk(1, 20)};
    @(negedge clk); fetch_valid = 0; fetch_skip = 0; #1;
    check(out_valid && out_mask == 4'b0011 && out_line == {64'h0, mk(1, 22), mk(0, 21)},
          "R9 skipped leading word", out_line, {64'h0, mk(1, 22), mk(0, 21)});
    do_flush();

    // R8: four unmarked words
    @(negedge clk);
    fetch_valid = 1;
    fetch_line = {mk(0, 33), mk(0, 32), mk(0, 31), mk(0, 30)};
    @(negedge clk); fetch_valid = 0; #1;
    check(out_err && !out_valid, "R8 format error flagged", {out_err, out_valid}, 2'b10);
    @(negedge clk); #1;
    check(!out_err && !out_valid && fetch_ready, "R8 bad words dropped", {out_err, out_valid, fetch_ready}, 3'b001);
    fetch_valid = 1;
    fetch_line = {mk(1, 43), mk(1, 42), mk(1, 41), mk(1, 40)};
    @(negedge clk); fetch_valid = 0; #1;
    check(out_valid && out_line == {96'h0, mk(1, 40)}, "R8 recovery after error", out_line, {96'h0, mk(1, 40)});
    do_flush();

    // R2 R10: fill limit, no skip
    acc = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      fetch_valid = 1; fetch_skip = 0;
      fetch_line = {mk(1, 4*c+3), mk(1, 4*c+2), mk(1, 4*c+1), mk(1, 4*c)};
      #1;
      if (!fetch_ready) break;
      acc++;
    end
    fetch_valid = 0;
    check(acc == 5, "R2 R10 five full lines accepted", 128'(acc), 128'd5);

    // R6: hold while dispatch stalls
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check(out_valid && out_mask == 4'b0001 && out_line == {96'h0, mk(1, 0)}, "R6 line held", out_line, {96'h0, mk(1, 0)});
    end
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0; #1;
    check(out_valid && out_line == {96'h0, mk(1, 1)}, "R6 advance on ready", out_line, {96'h0, mk(1, 1)});

    // R7: flush while fetch offers a line
    @(negedge clk);
    flush = 1; fetch_valid = 1;
    fetch_line = {mk(1, 53), mk(1, 52), mk(1, 51), mk(1, 50)};
    @(negedge clk); flush = 0; fetch_valid = 0; #1;
    check(!out_valid && fetch_ready && !out_err, "R7 flush empties", {out_valid, fetch_ready, out_err}, 3'b010);
    fetch_valid = 1;
    fetch_line = {mk(1, 63), mk(1, 62), mk(0, 61), mk(0, 60)};
    @(negedge clk); fetch_valid = 0; #1;
    check(out_valid && out_mask == 4'b0111 && out_line == {32'h0, mk(1, 62), mk(0, 61), mk(0, 60)},
          "R7 only post-flush line", out_line, {32'h0, mk(1, 62), mk(0, 61), mk(0, 60)});
    do_flush();

    // R2 R10: fill limit with skip 3
    acc = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      fetch_valid = 1; fetch_skip = 3;
      fetch_line = {mk(1, c), 96'h0};
      #1;
      if (!fetch_ready) break;
      acc++;
    end
    fetch_valid = 0; fetch_skip = 0;
    check(acc == 17, "R2 R10 seventeen single-word lines", 128'(acc), 128'd17);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule